// File: doc/BRIEF.md
# Ethernet Receive Frame Processor

This block turns a serial receive stream from a line decoder into stored frames. Its inputs are a data bit, a per-bit strobe in the system clock domain and carrier sense. It hunts for the alternating preamble and the start delimiter, then packs the following bits into octets, least significant bit first. It checks the destination address against a programmable station address, the all-ones broadcast address or a promiscuous override. Every octet runs through a four-stage delay line before it reaches the internal receive ring. The trailing four-octet check sequence is therefore checked against a running CRC-32 and never written.

Frames are written into the ring only tentatively. When carrier drops, the frame is either committed and becomes visible to the reader, or the write pointer is wound back to where the frame began. A frame is wound back when the address does not match, it is short, it has leftover bits, the CRC fails or the ring fills part way through. A one-cycle status report gives the error flags, whether the frame was kept, its octet count and whether its length/type field holds a type code. A host reads stored octets one at a time through a read strobe and can see when the ring is empty.

Top module: `eth_rx_frame`

## Requirements
- R1: After carrier rises, at least one octet of alternating bits (0x55, first bit on the line is bit 0) followed by the delimiter 0xD5 starts a frame. Later octets are assembled with the first received bit as bit 0, and stored octets equal the sent octets.
- R2: Each octet is held back four octet times, so the last four octets of a frame (its check sequence) are never stored. An accepted frame of N octets stores exactly N-4 octets.
- R3: If the ring fills while a frame is being written, the whole frame is discarded, `stat_ovf` is set, and previously committed frames stay intact.
- R4: A frame of fewer than 64 octets, check sequence included, sets `stat_short` and is discarded. A frame of exactly 64 octets is not short.
- R5: If carrier drops with 1 to 7 bits past the last whole octet, `stat_align` is set and the frame is discarded.
- R6: A CRC-32 (polynomial 0x04C11DB7, preset all ones, residue 0xC704DD7B over data plus check sequence) that fails sets `stat_crc` and the frame is discarded.
- R7: The length/type field is octets 12 (high) and 13 (low). `stat_is_type` is 1 when its value exceeds 1500 and 0 when it is 1500 or less.
- R8: A read strobe while `buf_empty` is 1 gives a one-cycle `rd_err` on the next cycle and no `rd_valid`.
- R9: A frame is accepted when octets 0..5 equal `sta_addr[47:40]`..`sta_addr[7:0]` in that order, or are all 0xFF, or when `promisc` is 1. Otherwise nothing from it becomes readable.
- R10: A discarded frame leaves the readable contents and `buf_empty` unchanged. An accepted frame carries none of the error flags.
- R11: `stat_valid` is a single-cycle pulse, two clock cycles after carrier falls. It comes with `stat_len` equal to the octet count including the check sequence.
- R12: A read strobe while `buf_empty` is 0 returns the oldest committed octet on `rd_data` with `rd_valid` one cycle later. Octets come out in received order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit_en | input | 1 | One-cycle strobe marking a valid received bit |
| rx_bit | input | 1 | Received data bit |
| rx_crs | input | 1 | Carrier sense; its fall ends a frame |
| sta_addr | input | 48 | Station address, first octet on the line in bits 47:40 |
| promisc | input | 1 | Accept every destination address |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Octet read from the ring |
| rd_valid | output | 1 | `rd_data` holds a fresh octet |
| rd_err | output | 1 | Read attempted on an empty ring |
| buf_empty | output | 1 | No committed octet waiting |
| stat_valid | output | 1 | Per-frame status pulse |
| stat_accept | output | 1 | Frame was committed to the ring |
| stat_short | output | 1 | Frame below 64 octets |
| stat_align | output | 1 | Leftover bits at frame end |
| stat_crc | output | 1 | Check sequence mismatch |
| stat_ovf | output | 1 | Ring filled during the frame |
| stat_is_type | output | 1 | Length/type field above 1500 |
| stat_len | output | LEN_W | Octets received, check sequence included |

## Verification
A delay line stuck at the wrong depth or a mis-packed octet shows at the read port as a wrong octet count or wrong data. It surfaces on the first accepted frame once it is drained. A write pointer that fails to wind back shows as `buf_empty` falling after a rejected frame, or as foreign octets between committed frames. That appears within two cycles of carrier dropping. A wrong CRC register or octet counter shows in the status pulse of the same frame, two cycles after carrier falls.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

  localparam logic [31:0] CRC_POLY    = 32'h04C11DB7;
  localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hC704DD7B;
  localparam logic [7:0]  PRE_OCTET   = 8'h55;
  localparam logic [7:0]  SFD_OCTET   = 8'hD5;
  localparam logic [15:0] LEN_LIMIT   = 16'd1500;
  localparam int          ADDR_BYTES  = 6;
  localparam int          LENF_HI     = 12;
  localparam int          LENF_LO     = 13;

  typedef enum logic [1:0] {FR_IDLE, FR_ADDR, FR_STORE, FR_DROP} fr_state_t;
  typedef enum logic {DS_HUNT, DS_DATA} ds_state_t;

  // one octet through the CRC, first line bit is bit 0
  function automatic logic [31:0] crc32_octet(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_rx_deser.sv
module eth_rx_deser
  import eth_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic       crs,
  output logic       sof,
  output logic       eof,
  output logic       frag,
  output logic       oct_v,
  output logic [7:0] oct_d
);
  ds_state_t   st;
  logic [7:0]  sh;
  logic [7:0]  nsh;
  logic [2:0]  bcnt;
  logic        pre_seen;

  always_comb nsh = {bit_in, sh[7:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= DS_HUNT;  sh <= '0;  bcnt <= '0;  pre_seen <= 1'b0;
      sof <= 1'b0;  eof <= 1'b0;  frag <= 1'b0;  oct_v <= 1'b0;  oct_d <= '0;
    end else begin
      sof   <= 1'b0;
      eof   <= 1'b0;
      oct_v <= 1'b0;
      if (!crs) begin
        if (st == DS_DATA) begin
          eof  <= 1'b1;
          frag <= (bcnt != 3'd0);
        end
        st <= DS_HUNT;  sh <= '0;  bcnt <= '0;  pre_seen <= 1'b0;
      end else if (bit_en) begin
        sh <= nsh;
        if (st == DS_HUNT) begin
          if (nsh == PRE_OCTET) pre_seen <= 1'b1;
          if (pre_seen && nsh == SFD_OCTET) begin
            st   <= DS_DATA;
            sof  <= 1'b1;
            bcnt <= '0;
          end
        end else begin
          bcnt <= bcnt + 3'd1;
          if (bcnt == 3'd7) begin
            oct_v <= 1'b1;
            oct_d <= nsh;
          end
        end
      end
    end
  end
endmodule

// File: rtl/eth_rx_crc.sv
module eth_rx_crc
  import eth_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       init,
  input  logic       en,
  input  logic [7:0] d,
  output logic       ok
);
  logic [31:0] crc;

  always_ff @(posedge clk) begin
    if (rst || init) crc <= CRC_INIT;
    else if (en)     crc <= crc32_octet(crc, d);
  end

  assign ok = (crc == CRC_RESIDUE);
endmodule

// File: rtl/eth_rx_ring.sv
module eth_rx_ring #(
  parameter int DEPTH = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wd,
  input  logic       commit,
  input  logic       rollback,
  input  logic       rd_en,
  output logic       full,
  output logic       empty,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       rd_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr;

  assign full  = ((wr_ptr - rd_ptr) == PW'(DEPTH));
  assign empty = (rd_ptr == cm_ptr);

  // storage array kept free of reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we && !full) mem[wr_ptr[AW-1:0]] <= wd;
    if (rd_en && !empty) rd_data <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;  cm_ptr <= '0;  rd_ptr <= '0;
      rd_valid <= 1'b0;  rd_err <= 1'b0;
    end else begin
      rd_valid <= rd_en && !empty;
      rd_err   <= rd_en && empty;
      if (rd_en && !empty) rd_ptr <= rd_ptr + PW'(1);
      if (rollback)            wr_ptr <= cm_ptr;
      else if (we && !full)    wr_ptr <= wr_ptr + PW'(1);
      if (commit) cm_ptr <= wr_ptr;
    end
  end
endmodule

// File: rtl/eth_rx_frame.sv
module eth_rx_frame
  import eth_rx_pkg::*;
#(
  parameter int DEPTH   = 2048,
  parameter int LEN_W   = 12,
  parameter int MIN_LEN = 64,
  parameter int DLY     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_bit_en,
  input  logic             rx_bit,
  input  logic             rx_crs,
  input  logic [47:0]      sta_addr,
  input  logic             promisc,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             rd_err,
  output logic             buf_empty,
  output logic             stat_valid,
  output logic             stat_accept,
  output logic             stat_short,
  output logic             stat_align,
  output logic             stat_crc,
  output logic             stat_ovf,
  output logic             stat_is_type,
  output logic [LEN_W-1:0] stat_len
);
  localparam int DW = $clog2(DLY + 1);

  logic             sof, eof, frag, oct_v;
  logic [7:0]       oct_d;
  logic             crc_ok;
  logic             ring_we, ring_full, ring_commit, ring_rollback;
  fr_state_t        st;
  logic [LEN_W-1:0] cnt;
  logic [DW-1:0]    dly_n;
  logic [7:0]       dly [DLY];
  logic             sta_hit, bc_hit, ovf;
  logic [15:0]      lenf;
  logic [7:0]       sta_b [ADDR_BYTES];
  logic [7:0]       addr_ref;
  logic             in_frame, short_now, accept_now, hit_now;

  eth_rx_deser u_deser (
    .clk(clk), .rst(rst), .bit_en(rx_bit_en), .bit_in(rx_bit), .crs(rx_crs),
    .sof(sof), .eof(eof), .frag(frag), .oct_v(oct_v), .oct_d(oct_d)
  );

  eth_rx_crc u_crc (
    .clk(clk), .rst(rst), .init(sof), .en(oct_v), .d(oct_d), .ok(crc_ok)
  );

  eth_rx_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst(rst), .we(ring_we), .wd(dly[DLY-1]),
    .commit(ring_commit), .rollback(ring_rollback), .rd_en(rd_en),
    .full(ring_full), .empty(buf_empty), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_err(rd_err)
  );

  // station address octets in line order
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_sta
    assign sta_b[g] = sta_addr[47 - 8*g -: 8];
  end

  always_comb begin
    addr_ref = 8'h00;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (cnt == LEN_W'(i)) addr_ref = sta_b[i];
  end

  assign in_frame   = (st != FR_IDLE);
  assign hit_now    = promisc || (sta_hit && oct_d == addr_ref) || (bc_hit && oct_d == 8'hFF);
  assign short_now  = (cnt < LEN_W'(MIN_LEN));
  assign accept_now = (st == FR_STORE) && !short_now && !frag && crc_ok && !ovf;
  assign ring_we    = oct_v && (st == FR_ADDR || st == FR_STORE) && (dly_n == DW'(DLY));
  assign ring_commit   = eof && in_frame && accept_now;
  assign ring_rollback = eof && in_frame && !accept_now;

  // delay line: oldest octet leaves from the last stage
  always_ff @(posedge clk) begin
    if (oct_v) begin
      dly[0] <= oct_d;
      for (int i = 1; i < DLY; i++) dly[i] <= dly[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= FR_IDLE;  cnt <= '0;  dly_n <= '0;
      sta_hit <= 1'b0;  bc_hit <= 1'b0;  ovf <= 1'b0;  lenf <= '0;
      stat_valid <= 1'b0;  stat_accept <= 1'b0;  stat_short <= 1'b0;
      stat_align <= 1'b0;  stat_crc <= 1'b0;  stat_ovf <= 1'b0;
      stat_is_type <= 1'b0;  stat_len <= '0;
    end else begin
      stat_valid <= 1'b0;
      if (sof) begin
        st <= FR_ADDR;  cnt <= '0;  dly_n <= '0;
        sta_hit <= 1'b1;  bc_hit <= 1'b1;  ovf <= 1'b0;  lenf <= '0;
      end else if (eof && in_frame) begin
        stat_valid   <= 1'b1;
        stat_accept  <= accept_now;
        stat_short   <= short_now;
        stat_align   <= frag;
        stat_crc     <= !crc_ok;
        stat_ovf     <= ovf;
        stat_is_type <= (cnt > LEN_W'(LENF_LO)) && (lenf > LEN_LIMIT);
        stat_len     <= cnt;
        st           <= FR_IDLE;
      end else if (oct_v && in_frame) begin
        if (cnt != '1) cnt <= cnt + LEN_W'(1);
        if (dly_n != DW'(DLY)) dly_n <= dly_n + DW'(1);
        if (cnt < LEN_W'(ADDR_BYTES)) begin
          sta_hit <= sta_hit && (oct_d == addr_ref);
          bc_hit  <= bc_hit && (oct_d == 8'hFF);
        end
        if (cnt == LEN_W'(ADDR_BYTES - 1))
          st <= hit_now ? FR_STORE : FR_DROP;
        if (cnt == LEN_W'(LENF_HI)) lenf[15:8] <= oct_d;
        if (cnt == LEN_W'(LENF_LO)) lenf[7:0]  <= oct_d;
        if (ring_we && ring_full) ovf <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eth_rx_frame_chk.sv
module eth_rx_frame_chk #(
  parameter int LEN_W   = 12,
  parameter int MIN_LEN = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             rd_err,
  input logic             buf_empty,
  input logic             stat_valid,
  input logic             stat_accept,
  input logic             stat_short,
  input logic             stat_align,
  input logic             stat_crc,
  input logic             stat_ovf,
  input logic [LEN_W-1:0] stat_len
);
  p_ovf_drop_r3: assert property (@(posedge clk) disable iff (rst)
    stat_valid && stat_ovf |-> !stat_accept);

  p_short_r4: assert property (@(posedge clk) disable iff (rst)
    stat_valid && (stat_len < LEN_W'(MIN_LEN)) |-> stat_short && !stat_accept);

  p_rderr_r8: assert property (@(posedge clk) disable iff (rst)
    rd_en && buf_empty |=> rd_err && !rd_valid);

  p_clean_accept_r10: assert property (@(posedge clk) disable iff (rst)
    stat_valid && stat_accept |-> !stat_crc && !stat_align && !stat_ovf && !stat_short);

  p_reject_hidden_r10: assert property (@(posedge clk) disable iff (rst)
    stat_valid && !stat_accept |-> !$fell(buf_empty));

  p_stat_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    stat_valid |=> !stat_valid);

  p_read_r12: assert property (@(posedge clk) disable iff (rst)
    rd_en && !buf_empty |=> rd_valid && !rd_err);
endmodule

bind eth_rx_frame eth_rx_frame_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_valid(rd_valid), .rd_err(rd_err),
  .buf_empty(buf_empty), .stat_valid(stat_valid), .stat_accept(stat_accept),
  .stat_short(stat_short), .stat_align(stat_align), .stat_crc(stat_crc),
  .stat_ovf(stat_ovf), .stat_len(stat_len)
);

// File: tb/eth_rx_frame_bench.sv
module eth_rx_frame_bench;
  localparam int LEN_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_bit_en = 1'b0, rx_bit = 1'b0, rx_crs = 1'b0;
  logic [47:0] sta_addr = 48'h02_11_22_33_44_55;
  logic promisc = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] rd_data;
  logic rd_valid, rd_err, buf_empty;
  logic stat_valid, stat_accept, stat_short, stat_align, stat_crc, stat_ovf, stat_is_type;
  logic [LEN_W-1:0] stat_len;

  int n_chk = 0, n_bad = 0;
  logic [7:0] frm[$];
  logic s_seen, s_acc, s_short, s_align, s_crc, s_ovf, s_type;
  int   s_len;

  always #2 clk = ~clk;

  eth_rx_frame #(.DEPTH(256), .LEN_W(LEN_W)) u_eth_rx_frame (
    .clk(clk), .rst(rst), .rx_bit_en(rx_bit_en), .rx_bit(rx_bit), .rx_crs(rx_crs),
    .sta_addr(sta_addr), .promisc(promisc), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_err(rd_err), .buf_empty(buf_empty),
    .stat_valid(stat_valid), .stat_accept(stat_accept), .stat_short(stat_short),
    .stat_align(stat_align), .stat_crc(stat_crc), .stat_ovf(stat_ovf),
    .stat_is_type(stat_is_type), .stat_len(stat_len)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic build(input logic [47:0] da, input logic [15:0] lf, input int n, input int seed);
    frm.delete();
    for (int i = 0; i < 6; i++) frm.push_back(da[47 - 8*i -: 8]);
    for (int i = 0; i < 6; i++) frm.push_back(8'hA0 + 8'(i));
    frm.push_back(lf[15:8]);
    frm.push_back(lf[7:0]);
    for (int i = 14; i < n; i++) frm.push_back(8'(seed + i * 7));
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b;  rx_bit_en = 1'b1;
    @(negedge clk);
    rx_bit_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // sends frm, then its check sequence (optionally corrupted), then extra bits
  task automatic send_frame(input bit bad_fcs, input int extra);
    logic [31:0] c, f;
    c = 32'hFFFFFFFF;
    @(negedge clk);
    rx_crs = 1'b1;
    for (int k = 0; k < 7; k++)
      for (int i = 0; i < 8; i++) send_bit(8'h55 >> i);
    for (int i = 0; i < 8; i++) send_bit(8'hD5 >> i);
    foreach (frm[k])
      for (int i = 0; i < 8; i++) begin
        if (c[31] ^ frm[k][i]) c = {c[30:0], 1'b0} ^ 32'h04C11DB7;
        else                   c = {c[30:0], 1'b0};
        send_bit(frm[k][i]);
      end
    f = ~c;
    if (bad_fcs) f[5] = ~f[5];
    for (int i = 31; i >= 0; i--) send_bit(f[i]);
    for (int i = 0; i < extra; i++) send_bit(i[0]);
    @(negedge clk);
    rx_crs = 1'b0;
    s_seen = 1'b0;
    for (int t = 0; t < 40 && !s_seen; t++) begin
      @(negedge clk);
      if (stat_valid) begin
        s_seen = 1'b1;
        s_acc = stat_accept;  s_short = stat_short;  s_align = stat_align;
        s_crc = stat_crc;     s_ovf = stat_ovf;      s_type = stat_is_type;
        s_len = int'(stat_len);
      end
    end
    chk(s_seen, "R11", "status pulse seen", s_seen, 1);
  endtask

  task automatic read_check(input logic [7:0] exp[$], input string req);
    int bad;
    bad = 0;
    foreach (exp[k]) begin
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      if (!rd_valid || rd_data !== exp[k]) bad++;
    end
    chk(bad == 0, req, "stored octets mismatching", bad, 0);
    chk(buf_empty === 1'b1, req, "empty after drain (check octets not stored)", buf_empty, 1);
  endtask

  task automatic t_reset;
    chk(buf_empty === 1'b1, "R12", "reset buf_empty", buf_empty, 1);
    chk(stat_valid === 1'b0, "R11", "reset stat_valid", stat_valid, 0);
    chk(rd_valid === 1'b0, "R12", "reset rd_valid", rd_valid, 0);
  endtask

  task automatic t_unicast_min;
    build(sta_addr, 16'h0030, 60, 3);
    send_frame(1'b0, 0);
    chk(s_acc === 1'b1, "R9", "station frame accepted", s_acc, 1);
    chk(s_short === 1'b0, "R4", "64-octet frame not short", s_short, 0);
    chk(s_len == 64, "R11", "stat_len", s_len, 64);
    chk(buf_empty === 1'b0, "R10", "committed frame visible", buf_empty, 0);
    read_check(frm, "R1 R2 R12");
  endtask

  task automatic t_broadcast;
    build(48'hFFFF_FFFF_FFFF, 16'h0800, 80, 9);
    send_frame(1'b0, 0);
    chk(s_acc === 1'b1, "R9", "broadcast accepted", s_acc, 1);
    read_check(frm, "R2");
  endtask

  task automatic t_filter_reject;
    build(48'h02_11_22_33_44_56, 16'h0800, 70, 1);
    send_frame(1'b0, 0);
    chk(s_acc === 1'b0, "R9", "foreign address rejected", s_acc, 0);
    chk(buf_empty === 1'b1, "R10", "rejected frame invisible", buf_empty, 1);
  endtask

  task automatic t_promisc;
    promisc = 1'b1;
    build(48'h02_11_22_33_44_56, 16'h0800, 70, 5);
    send_frame(1'b0, 0);
    promisc = 1'b0;
    chk(s_acc === 1'b1, "R9", "promiscuous accepts foreign", s_acc, 1);
    read_check(frm, "R9");
  endtask

  task automatic t_bad_crc;
    build(sta_addr, 16'h0800, 70, 2);
    send_frame(1'b1, 0);
    chk(s_crc === 1'b1, "R6", "crc flag", s_crc, 1);
    chk(s_acc === 1'b0, "R6", "crc frame dropped", s_acc, 0);
    chk(buf_empty === 1'b1, "R10", "crc frame invisible", buf_empty, 1);
  endtask

  task automatic t_short;
    build(sta_addr, 16'h0800, 59, 4);
    send_frame(1'b0, 0);
    chk(s_short === 1'b1, "R4", "63-octet frame short", s_short, 1);
    chk(s_crc === 1'b0, "R6", "short frame crc ok", s_crc, 0);
    chk(buf_empty === 1'b1, "R4", "short frame invisible", buf_empty, 1);
  endtask

  task automatic t_align;
    build(sta_addr, 16'h0800, 60, 6);
    send_frame(1'b0, 3);
    chk(s_align === 1'b1, "R5", "leftover bits flagged", s_align, 1);
    chk(s_acc === 1'b0, "R5", "misaligned frame dropped", s_acc, 0);
    chk(s_len == 64, "R5", "fragment not counted", s_len, 64);
    chk(buf_empty === 1'b1, "R5", "misaligned frame invisible", buf_empty, 1);
  endtask

  task automatic t_type_field;
    build(sta_addr, 16'd1500, 64, 8);
    send_frame(1'b0, 0);
    chk(s_type === 1'b0, "R7", "1500 is a length", s_type, 0);
    read_check(frm, "R7");
    build(sta_addr, 16'd1501, 64, 8);
    send_frame(1'b0, 0);
    chk(s_type === 1'b1, "R7", "1501 is a type", s_type, 1);
    read_check(frm, "R7");
  endtask

  task automatic t_overflow;
    logic [7:0] first[$];
    build(sta_addr, 16'h0800, 150, 11);
    first = frm;
    send_frame(1'b0, 0);
    chk(s_acc === 1'b1, "R3", "first frame fits", s_acc, 1);
    build(sta_addr, 16'h0800, 120, 12);
    send_frame(1'b0, 0);
    chk(s_ovf === 1'b1, "R3", "overflow flagged", s_ovf, 1);
    chk(s_acc === 1'b0, "R3", "overflowing frame dropped", s_acc, 0);
    read_check(first, "R3");
  endtask

  task automatic t_read_empty;
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_err === 1'b1, "R8", "rd_err on empty read", rd_err, 1);
    chk(rd_valid === 1'b0, "R8", "no data on empty read", rd_valid, 0);
    @(negedge clk);
    chk(rd_err === 1'b0, "R8", "rd_err one cycle", rd_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unicast_min();
    t_broadcast();
    t_filter_reject();
    t_promisc();
    t_bad_crc();
    t_short();
    t_align();
    t_type_field();
    t_overflow();
    t_read_empty();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule